// File: doc/BRIEF.md
# Multi-Mode DMA Channel Engine

This block is a single programmable DMA channel. Software loads a source address, a destination address, a transfer count and a control word through a small register write port. Once enabled, the channel moves data through a plain read/write memory port, one read phase followed by one write phase per transfer. A transfer begins after a rising edge on the trigger input, while the trigger is held high (level mode), or after a software request.

The channel steps private working copies of the two addresses and the count, so the programmed values survive and are restored at the end of every block. Each side can be byte or word wide, with zero-fill or truncation between the two. Single, block and burst-block modes each exist in a one-shot and an auto-repeat form. Burst-block hands the bus back to the CPU periodically. An NMI can end a running service after the transfer in progress.

Top module: `dma_xfer_channel`

## Requirements
- R1: The control word (register select 0) holds enable at bit 0, software request at bit 1, mode at bits 4:2, source step at 6:5, destination step at 8:7, source-is-byte at 9, destination-is-byte at 10, level trigger at 11, NMI abort enable at 12, end-of-block flag at 13 and abort flag at 14. Mode 000 is single, 001 block, 010/011 burst-block, 100 repeated single, 101 repeated block, 110/111 repeated burst-block. One trigger in block mode performs the whole block. Select 1 is source, select 2 is destination and select 3 is count.
- R2: The programmed source, destination and count are copied to working registers when a service starts. Only the copies advance, and they are restored from the programmed values at the end of every block, so a repeated block reuses the same addresses.
- R3: When the working count reaches zero, the end-of-block flag (ch_irq) sets and the count reloads. A programmed count of zero produces no transfer and no flag.
- R4: One-shot modes clear the enable at the end of the block. Repeating modes keep the enable set. Repeated burst-block starts the next block with no new trigger.
- R5: A step field of 00 or 01 holds the address, 10 decrements it and 11 increments it. The step size is 1 for a byte side and 2 for a word side.
- R6: A byte source written to a word destination has its upper byte zeroed. A word source written to a byte destination writes only the low byte, with mem_wdata[15:8] equal to zero.
- R7: In level mode, transfers proceed while the trigger is high. If the trigger falls mid-block, the channel pauses with all state kept and resumes at the next address when the trigger returns high.
- R8: Triggers that arrive while a block is running are ignored. Single mode performs exactly one transfer per trigger.
- R9: In burst-block mode, after every fourth transfer of a block, bus_req drops for exactly two cycles before the next transfer.
- R10: With NMI abort enabled, an NMI during a service lets the current transfer finish, then clears the enable, stops the service and sets the abort flag (ch_abort).
- R11: Writing 1 to the software request bit starts a service once. The bit is not stored, so a later control write with the bit at 0 starts nothing.
- R12: Each transfer is one read cycle (mem_rd) followed directly by one write cycle (mem_wr). The first read of a service waits until bus_grant is high.
- R13: After reset the channel is disabled, both flags are clear and no bus request or memory strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 count |
| reg_wdata | input | 16 | Register write data |
| trig | input | 1 | Hardware trigger |
| nmi | input | 1 | Non-maskable interrupt request |
| bus_grant | input | 1 | Bus granted to the channel |
| mem_rdata | input | 16 | Read data, returned in the read cycle |
| bus_req | output | 1 | Channel requests or holds the bus |
| mem_rd | output | 1 | Read phase strobe |
| mem_wr | output | 1 | Write phase strobe |
| mem_byte | output | 1 | Current access is a byte |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Write data |
| ch_enable | output | 1 | Channel enable bit |
| ch_irq | output | 1 | End-of-block flag |
| ch_abort | output | 1 | NMI abort flag |

## Verification
A corrupted working address or count appears at the next write as a wrong mem_addr or mem_wdata, or as a block that ends one transfer early or late. A scoreboard of expected writes catches either within one transfer of the fault. A stuck block-active or burst counter shows up at the ports as an extra or missing transfer, as a bus_req gap of the wrong length, or as an enable that stays set or clears at the wrong time. The bench samples each of these at the point where the block should have ended.

// File: rtl/dma_xfer_channel.sv
`timescale 1ns/1ps
module dma_xfer_channel #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BURST_BEATS = 4,
  parameter int YIELD_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          trig,
  input  logic          nmi,
  input  logic          bus_grant,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_req,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          mem_byte,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          ch_enable,
  output logic          ch_irq,
  output logic          ch_abort
);
  localparam int WSTEP = DW / 8;
  localparam int BCW = $clog2(BURST_BEATS + 1);
  localparam int YCW = $clog2(YIELD_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RD, S_WR, S_YLD} st_t;
  st_t state;

  logic          en_q, sb_q, db_q, lvl_q, nmie_q, irq_q, abt_q;
  logic [2:0]    mode_q;
  logic [1:0]    sstep_q, dstep_q;
  logic [AW-1:0] src_q, dst_q, size_q, wsrc, wdst, wsize;
  logic [DW-1:0] data_q;
  logic          fresh, blk_act, sw_pend, trig_q, nmi_hit;
  logic [BCW-1:0] beat;
  logic [YCW-1:0] ycnt;

  wire is_single = (mode_q[1:0] == 2'b00);
  wire is_burst  = mode_q[1];
  wire rpt       = mode_q[2];
  wire ctl_wr    = reg_we && (reg_sel == 2'd0);
  wire nmi_now   = nmi_hit || (nmi && nmie_q);
  wire go_on     = en_q && (!lvl_q || trig);
  wire last      = (wsize == AW'(1));
  wire start_ok  = en_q && (size_q != '0) &&
                   (blk_act ? (!lvl_q || trig)
                            : (sw_pend || (lvl_q ? trig : (trig && !trig_q))));
  wire do_abort  = nmi_now && ((state == S_IDLE && blk_act) || state == S_REQ ||
                               state == S_YLD || state == S_WR);
  logic unused_bits;
  assign unused_bits = ^reg_wdata[AW-1:15];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m,
                                         input logic bytew);
    logic [AW-1:0] inc;
    inc = bytew ? AW'(1) : AW'(WSTEP);
    case (m)
      2'b10:   return a - inc;
      2'b11:   return a + inc;
      default: return a;
    endcase
  endfunction

  assign bus_req   = (state == S_REQ) || (state == S_RD) || (state == S_WR);
  assign mem_rd    = (state == S_RD);
  assign mem_wr    = (state == S_WR);
  assign mem_addr  = mem_rd ? wsrc : wdst;
  assign mem_byte  = mem_rd ? sb_q : db_q;
  assign mem_wdata = db_q ? {{(DW-8){1'b0}}, data_q[7:0]} : data_q;
  assign ch_enable = en_q;
  assign ch_irq    = irq_q;
  assign ch_abort  = abt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      {en_q, sb_q, db_q, lvl_q, nmie_q, irq_q, abt_q} <= '0;
      mode_q <= '0; sstep_q <= '0; dstep_q <= '0;
      src_q <= '0; dst_q <= '0; size_q <= '0;
      wsrc <= '0; wdst <= '0; wsize <= '0; data_q <= '0;
      fresh <= 1'b1; blk_act <= 1'b0; sw_pend <= 1'b0; trig_q <= 1'b0; nmi_hit <= 1'b0;
      beat <= '0; ycnt <= '0;
    end else begin
      trig_q  <= trig;
      sw_pend <= ctl_wr && reg_wdata[1];
      if (nmi && nmie_q && (state != S_IDLE || blk_act)) nmi_hit <= 1'b1;
      if (reg_we) begin
        case (reg_sel)
          2'd0: begin
            en_q <= reg_wdata[0];     mode_q <= reg_wdata[4:2];
            sstep_q <= reg_wdata[6:5]; dstep_q <= reg_wdata[8:7];
            sb_q <= reg_wdata[9];     db_q <= reg_wdata[10];
            lvl_q <= reg_wdata[11];   nmie_q <= reg_wdata[12];
            irq_q <= reg_wdata[13];   abt_q <= reg_wdata[14];
          end
          2'd1:    begin src_q  <= reg_wdata; fresh <= 1'b1; end
          2'd2:    begin dst_q  <= reg_wdata; fresh <= 1'b1; end
          default: begin size_q <= reg_wdata; fresh <= 1'b1; end
        endcase
      end
      if (do_abort) begin
        en_q <= 1'b0; abt_q <= 1'b1; blk_act <= 1'b0; fresh <= 1'b1;
        nmi_hit <= 1'b0; beat <= '0; state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: begin
            nmi_hit <= 1'b0;
            if (!en_q) blk_act <= 1'b0;
            else if (start_ok) begin
              if (fresh && !blk_act) begin
                wsrc <= src_q; wdst <= dst_q; wsize <= size_q; fresh <= 1'b0;
              end
              if (!blk_act) beat <= '0;
              blk_act <= !is_single;
              state   <= S_REQ;
            end
          end
          S_REQ: begin
            if (!en_q) begin state <= S_IDLE; blk_act <= 1'b0; end
            else if (blk_act && lvl_q && !trig) state <= S_IDLE;
            else if (bus_grant) state <= S_RD;
          end
          S_RD: begin
            data_q <= sb_q ? {{(DW-8){1'b0}}, mem_rdata[7:0]} : mem_rdata;
            state  <= S_WR;
          end
          S_WR: begin
            if (last) begin
              irq_q <= 1'b1;
              wsrc <= src_q; wdst <= dst_q; wsize <= size_q; beat <= '0;
              if (!rpt) en_q <= 1'b0;
              if (rpt && is_burst) state <= S_REQ;
              else begin state <= S_IDLE; blk_act <= 1'b0; end
            end else begin
              wsrc  <= step(wsrc, sstep_q, sb_q);
              wdst  <= step(wdst, dstep_q, db_q);
              wsize <= wsize - AW'(1);
              if (is_single) state <= S_IDLE;
              else if (is_burst && beat == BCW'(BURST_BEATS - 1)) begin
                beat <= '0; ycnt <= '0; state <= S_YLD;
              end else begin
                if (is_burst) beat <= beat + BCW'(1);
                if (go_on) state <= bus_grant ? S_RD : S_REQ;
                else state <= S_IDLE;
              end
            end
          end
          S_YLD: begin
            if (ycnt == YCW'(YIELD_CYCLES - 1)) state <= S_REQ;
            else ycnt <= ycnt + YCW'(1);
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (mem_wr && !mem_rd)); // R12
  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |-> $past(bus_grant)); // R12
  AST_FLAG_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ch_irq) && !$past(reg_we)) |-> $past(mem_wr)); // R3
  AST_ONESHOT_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ch_irq) && !$past(reg_we) && !mode_q[2]) |-> !ch_enable); // R4
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ch_abort) && !$past(reg_we)) |-> (!ch_enable && !bus_req)); // R10
  AST_NARROW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_byte) |-> (mem_wdata[DW-1:8] == '0)); // R6
endmodule

// File: tb/tb_dma_xfer_channel.sv
`timescale 1ns/1ps
module tb_dma_xfer_channel;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic trig = 1'b0, nmi = 1'b0, bus_grant = 1'b1;
  logic [15:0] mem_rdata, mem_addr, mem_wdata;
  logic bus_req, mem_rd, mem_wr, mem_byte, ch_enable, ch_irq, ch_abort;

  always #2 clk = ~clk;

  dma_xfer_channel dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .trig(trig), .nmi(nmi), .bus_grant(bus_grant),
    .mem_rdata(mem_rdata), .bus_req(bus_req), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ch_enable(ch_enable), .ch_irq(ch_irq), .ch_abort(ch_abort));

  function automatic logic [15:0] pat(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] + 8'h31};
  endfunction
  assign mem_rdata = pat(mem_addr);

  function automatic logic [15:0] dat(input logic [15:0] a, input bit sb, input bit db);
    logic [15:0] v;
    v = pat(a);
    if (sb || db) v = {8'h00, v[7:0]};
    return v;
  endfunction

  function automatic logic [15:0] cw(input bit en, input bit sw, input logic [2:0] md,
      input logic [1:0] ss, input logic [1:0] ds, input bit sb, input bit db,
      input bit lvl, input bit nme);
    return {3'b000, nme, lvl, db, sb, ds, ss, md, sw, en};
  endfunction

  int checks = 0, fails = 0, wr_seen = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic [15:0] d, input string tag);
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      wr_seen++;
      if (exp_q.size() == 0) check(1'b0, "R8", "unexpected write", {mem_addr, mem_wdata}, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({mem_addr, mem_wdata} == e, t, "write addr/data", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic wreg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic setup(input logic [15:0] s, input logic [15:0] d, input logic [15:0] n);
    wreg(2'd1, s); wreg(2'd2, d); wreg(2'd3, n);
  endtask

  task automatic pulse_trig;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int base, n, lowcnt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check(!ch_enable && !ch_irq && !ch_abort, "R13", "flags after reset",
          {ch_enable, ch_irq, ch_abort}, 0);
    check(!bus_req && !mem_rd && !mem_wr, "R13", "strobes after reset",
          {bus_req, mem_rd, mem_wr}, 0);

    // R1 block mode, word increment
    setup(16'h0010, 16'h0100, 16'd3);
    wreg(2'd0, cw(1, 0, 3'b001, 2'b11, 2'b11, 0, 0, 0, 0));
    push(16'h0100, pat(16'h0010), "R1");
    push(16'h0102, pat(16'h0012), "R1");
    push(16'h0104, pat(16'h0014), "R1");
    pulse_trig(); idle(20);
    check(exp_q.size() == 0, "R1", "whole block on one trigger", exp_q.size(), 0);
    check(ch_irq == 1'b1, "R3", "end-of-block flag", ch_irq, 1);
    check(ch_enable == 1'b0, "R4", "one-shot enable cleared", ch_enable, 0);

    // R8 single mode, byte source held, word destination decrement
    setup(16'h0021, 16'h0200, 16'd2);
    wreg(2'd0, cw(1, 0, 3'b000, 2'b00, 2'b10, 1, 0, 0, 0));
    base = wr_seen;
    push(16'h0200, dat(16'h0021, 1, 0), "R6");
    pulse_trig(); idle(15);
    check(wr_seen - base == 1, "R8", "one transfer per trigger", wr_seen - base, 1);
    check(ch_enable && !ch_irq, "R8", "single mid-block state", {ch_enable, ch_irq}, 2);
    push(16'h01FE, dat(16'h0021, 1, 0), "R5");
    pulse_trig(); idle(15);
    check(ch_irq && !ch_enable, "R4", "single block done", {ch_irq, ch_enable}, 2);

    // R6 word source to byte destination, byte step
    setup(16'h0030, 16'h0300, 16'd2);
    wreg(2'd0, cw(1, 0, 3'b001, 2'b11, 2'b11, 0, 1, 0, 0));
    push(16'h0300, dat(16'h0030, 0, 1), "R6");
    push(16'h0301, dat(16'h0032, 0, 1), "R5");
    pulse_trig(); idle(15);
    check(exp_q.size() == 0, "R6", "narrow writes done", exp_q.size(), 0);

    // R11 software request, self-clearing
    setup(16'h0040, 16'h0400, 16'd1);
    push(16'h0400, pat(16'h0040), "R11");
    wreg(2'd0, cw(1, 1, 3'b101, 2'b11, 2'b11, 0, 0, 0, 0));
    idle(15);
    check(exp_q.size() == 0, "R11", "software start", exp_q.size(), 0);
    base = wr_seen;
    wreg(2'd0, cw(1, 0, 3'b101, 2'b11, 2'b11, 0, 0, 0, 0));
    idle(15);
    check(wr_seen == base, "R11", "request bit not retained", wr_seen - base, 0);
    check(ch_enable == 1'b1, "R4", "repeat mode keeps enable", ch_enable, 1);
    wreg(2'd0, 16'h0000);

    // R3 zero count
    setup(16'h0000, 16'h0000, 16'd0);
    wreg(2'd0, cw(1, 0, 3'b001, 2'b11, 2'b11, 0, 0, 0, 0));
    base = wr_seen;
    pulse_trig(); idle(10);
    check(wr_seen == base, "R3", "zero count no transfer", wr_seen - base, 0);
    check(ch_irq == 1'b0, "R3", "zero count no flag", ch_irq, 0);
    wreg(2'd0, 16'h0000);

    // R2 / R8 repeated block with an ignored mid-block trigger
    setup(16'h0050, 16'h0500, 16'd2);
    wreg(2'd0, cw(1, 0, 3'b101, 2'b11, 2'b11, 0, 0, 0, 0));
    base = wr_seen;
    push(16'h0500, pat(16'h0050), "R8");
    push(16'h0502, pat(16'h0052), "R8");
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    idle(15);
    check(wr_seen - base == 2, "R8", "mid-block trigger ignored", wr_seen - base, 2);
    check(ch_enable && ch_irq, "R4", "repeat block keeps enable", {ch_enable, ch_irq}, 3);
    push(16'h0500, pat(16'h0050), "R2");
    push(16'h0502, pat(16'h0052), "R2");
    pulse_trig(); idle(15);
    check(wr_seen - base == 4 && exp_q.size() == 0, "R2", "block restarts at programmed address",
          wr_seen - base, 4);
    wreg(2'd0, 16'h0000);

    // R12 bus grant wait and phase order
    bus_grant = 1'b0;
    setup(16'h0060, 16'h0600, 16'd1);
    wreg(2'd0, cw(1, 0, 3'b001, 2'b11, 2'b11, 0, 0, 0, 0));
    push(16'h0600, pat(16'h0060), "R12");
    pulse_trig(); idle(5);
    check(bus_req && !mem_rd, "R12", "waiting for grant", {bus_req, mem_rd}, 2);
    @(negedge clk); bus_grant = 1'b1;
    @(negedge clk);
    check(mem_rd && !mem_wr, "R12", "read phase after grant", {mem_rd, mem_wr}, 2);
    @(negedge clk);
    check(mem_wr && !mem_rd, "R12", "write phase follows", {mem_rd, mem_wr}, 1);
    idle(10);

    // R9 burst-block yield
    setup(16'h0070, 16'h0700, 16'd6);
    wreg(2'd0, cw(1, 0, 3'b010, 2'b11, 2'b11, 0, 0, 0, 0));
    for (int i = 0; i < 6; i++) push(16'h0700 + 16'(2 * i), pat(16'h0070 + 16'(2 * i)), "R9");
    n = 0; lowcnt = 0;
    @(negedge clk); trig = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); trig = 1'b0;
      if (mem_wr) n++;
      else if (n == 4 && !bus_req) lowcnt++;
    end
    check(n == 6, "R9", "burst transfer count", n, 6);
    check(lowcnt == 2, "R9", "bus released cycles", lowcnt, 2);
    check(!ch_enable && exp_q.size() == 0, "R4", "burst one-shot done", ch_enable, 0);

    // R7 level trigger pause and resume
    setup(16'h0080, 16'h0800, 16'd4);
    wreg(2'd0, cw(1, 0, 3'b001, 2'b11, 2'b11, 0, 0, 1, 0));
    for (int i = 0; i < 4; i++) push(16'h0800 + 16'(2 * i), pat(16'h0080 + 16'(2 * i)), "R7");
    base = wr_seen; n = 0;
    @(negedge clk); trig = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (mem_wr) n++;
      if (n == 2) break;
    end
    trig = 1'b0;
    idle(10);
    check(wr_seen - base == 2, "R7", "paused while trigger low", wr_seen - base, 2);
    check(ch_enable && !bus_req, "R7", "pause keeps enable", {ch_enable, bus_req}, 2);
    trig = 1'b1; idle(12); trig = 1'b0;
    check(exp_q.size() == 0 && wr_seen - base == 4, "R7", "resumed at next address",
          wr_seen - base, 4);
    check(ch_irq == 1'b1, "R3", "level block flag", ch_irq, 1);

    // R10 NMI abort
    setup(16'h0090, 16'h0900, 16'd8);
    wreg(2'd0, cw(1, 0, 3'b001, 2'b11, 2'b11, 0, 0, 0, 1));
    push(16'h0900, pat(16'h0090), "R10");
    push(16'h0902, pat(16'h0092), "R10");
    base = wr_seen; n = 0;
    @(negedge clk); trig = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); trig = 1'b0;
      if (mem_wr) n++;
      if (n == 2) break;
    end
    nmi = 1'b1;
    @(negedge clk); nmi = 1'b0;
    idle(10);
    check(wr_seen - base == 2, "R10", "transfers after NMI", wr_seen - base, 2);
    check(ch_abort && !ch_enable, "R10", "abort flag and enable", {ch_abort, ch_enable}, 2);
    pulse_trig(); idle(10);
    check(wr_seen - base == 2, "R10", "no restart after abort", wr_seen - base, 2);

    // R4 repeated burst-block restarts on its own
    setup(16'h00A0, 16'h0A00, 16'd2);
    wreg(2'd0, cw(1, 0, 3'b110, 2'b11, 2'b11, 0, 0, 0, 0));
    for (int k = 0; k < 3; k++) begin
      push(16'h0A00, pat(16'h00A0), "R4");
      push(16'h0A02, pat(16'h00A2), "R4");
    end
    base = wr_seen; n = 0;
    @(negedge clk); trig = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); trig = 1'b0;
      if (mem_wr) n++;
      if (n == 6) break;
    end
    reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = cw(0, 0, 3'b110, 2'b11, 2'b11, 0, 0, 0, 0);
    @(negedge clk); reg_we = 1'b0;
    idle(10);
    check(wr_seen - base == 6, "R4", "blocks without new trigger", wr_seen - base, 6);
    check(!ch_enable && exp_q.size() == 0, "R4", "stopped by software", ch_enable, 0);

    summary();
    $finish;
  end
endmodule